// File: doc/BRIEF.md
# Arbitrated Test-and-Set Lock Bank

This block holds a bank of one-bit lock words that several requesters share through a single bus. Every cycle a round-robin arbiter picks one active requester, and only that requester reaches the lock bank. It can read a word, write a bit into it, or perform a test-and-set. A test-and-set returns the word's previous value and leaves the word at 1. The read and the set happen in the same granted bus operation, so nothing can come between them.

When several requesters try to take the same free lock in the same cycle, exactly one of them sees 0 and owns the lock. Every other requester sees 1. A requester holds its request until its grant bit is high. One cycle after that grant, a completion pulse carries the requester's index and the old bit. A lock is released by writing 0 to it.

Top module: `swap_lock_bus`

## Requirements
- R1: At most one grant bit is high in any cycle, and a grant only goes to a requester whose request is high.
- R2: In any cycle where at least one request is high, one of them is granted in that same cycle.
- R3: Round-robin order: the search starts at the requester just after the previous grant holder and wraps around. After reset, requester 0 has the highest priority.
- R4: A completion pulse (`rsp_valid`) occurs exactly one cycle after each grant and in no other cycle. It carries the index of the granted requester.
- R5: Operation code 2 (test-and-set) returns the lock's previous value and leaves the lock at 1.
- R6: When several requesters test-and-set the same free lock in the same cycle, exactly one of them gets 0 and all the others get 1.
- R7: Operation code 1 (write) stores `req_wdata` into the lock and returns the previous value. Writing 0 releases the lock.
- R8: Operation code 0 (read) returns the lock value and leaves it unchanged.
- R9: A test-and-set on a lock that is already 1 returns 1 and leaves the lock at 1.
- R10: Reset clears every lock to 0 and suppresses the completion pulse.
- R11: Operation code 3 behaves exactly like a read.
- R12: An access changes only the addressed lock word. The other words keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_REQ | Request line per requester, held until granted |
| req_op | input | 2*NUM_REQ | Operation per requester: 0 read, 1 write, 2 test-and-set, 3 read |
| req_addr | input | ADDR_W*NUM_REQ | Lock index per requester |
| req_wdata | input | NUM_REQ | Bit stored by a write |
| gnt | output | NUM_REQ | One-hot grant, combinational from the requests |
| rsp_valid | output | 1 | Completion pulse, one cycle after a grant |
| rsp_id | output | ID_W | Index of the requester being answered |
| rsp_data | output | 1 | Lock value before the access |

## Verification
The following grant and response properties hold in every cycle, so they are checked continuously:
- the grant is one-hot and only goes to a requester that is asking;
- an active request never goes without a grant;
- every grant, and only a grant, produces a completion pulse on the following cycle;
- that pulse names the granted requester.

Other behaviour can only be shown by the bench's scenarios:
- the values returned by each operation code;
- the single zero when several test-and-sets contend for one lock;
- release by write;
- the isolation of neighbouring words;
- the exact round-robin order;
- the restart of lock values and priority after a reset in mid-run.

// File: rtl/swap_lock_pkg.sv
package swap_lock_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SWAP  = 2'd2,
        OP_RSVD  = 2'd3
    } lock_op_e;

endpackage

// File: rtl/swap_lock_arb.sv
module swap_lock_arb #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             gnt_any
);
    typedef struct packed {
        logic [IDX_W-1:0] last;
    } arb_state_t;

    arb_state_t st_d, st_q;

    // The search begins just after the previous holder, so that holder comes last (R3).
    always_comb begin
        st_d    = st_q;
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int cand;
            cand = (int'(st_q.last) + k) % N;
            if (!gnt_any && req[cand]) begin
                gnt_any   = 1'b1;
                gnt[cand] = 1'b1;
                gnt_idx   = IDX_W'(cand);
            end
        end
        if (gnt_any) begin
            st_d.last = gnt_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.last <= IDX_W'(N - 1);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/swap_lock_store.sv
module swap_lock_store
    import swap_lock_pkg::*;
#(
    parameter int NUM_LOCKS = 8,
    parameter int ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  lock_op_e          acc_op,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wdata,
    output logic              old_bit
);
    logic [NUM_LOCKS-1:0] lock_d, lock_q;
    logic                 in_range;

    always_comb begin
        lock_d   = lock_q;
        in_range = (int'(acc_addr) < NUM_LOCKS);
        old_bit  = in_range ? lock_q[acc_addr] : 1'b0;
        if (acc_en && in_range) begin
            unique case (acc_op)
                OP_SWAP:  lock_d[acc_addr] = 1'b1;       // test and set in one step (R5)
                OP_WRITE: lock_d[acc_addr] = acc_wdata;  // release by writing 0 (R7)
                default:  lock_d[acc_addr] = lock_q[acc_addr];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else begin
            lock_q <= lock_d;
        end
    end
endmodule

// File: rtl/swap_lock_resp.sv
module swap_lock_resp #(
    parameter int ID_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic [ID_W-1:0] fire_id,
    input  logic            fire_data,
    output logic            rsp_valid,
    output logic [ID_W-1:0] rsp_id,
    output logic            rsp_data
);
    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
        logic            data;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d.valid = fire;
        rsp_d.id    = fire ? fire_id : rsp_q.id;
        rsp_d.data  = fire ? fire_data : rsp_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_id    = rsp_q.id;
    assign rsp_data  = rsp_q.data;
endmodule

// File: rtl/swap_lock_bus.sv
module swap_lock_bus
    import swap_lock_pkg::*;
#(
    parameter int NUM_REQ   = 4,
    parameter int NUM_LOCKS = 8,
    parameter int ADDR_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1,
    parameter int ID_W      = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        req_valid,
    input  logic [2*NUM_REQ-1:0]      req_op,
    input  logic [ADDR_W*NUM_REQ-1:0] req_addr,
    input  logic [NUM_REQ-1:0]        req_wdata,
    output logic [NUM_REQ-1:0]        gnt,
    output logic                      rsp_valid,
    output logic [ID_W-1:0]           rsp_id,
    output logic                      rsp_data
);
    logic [ID_W-1:0]   win_idx;
    logic              win_any;
    lock_op_e          sel_op;
    logic [ADDR_W-1:0] sel_addr;
    logic              sel_wdata;
    logic              old_bit;

    swap_lock_arb #(.N(NUM_REQ), .IDX_W(ID_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .gnt     (gnt),
        .gnt_idx (win_idx),
        .gnt_any (win_any)
    );

    // Only the granted requester's fields reach the lock bank (R1).
    always_comb begin
        sel_op    = lock_op_e'(req_op[win_idx*2 +: 2]);
        sel_addr  = req_addr[win_idx*ADDR_W +: ADDR_W];
        sel_wdata = req_wdata[win_idx];
    end

    swap_lock_store #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (win_any),
        .acc_op    (sel_op),
        .acc_addr  (sel_addr),
        .acc_wdata (sel_wdata),
        .old_bit   (old_bit)
    );

    swap_lock_resp #(.ID_W(ID_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (win_any),
        .fire_id   (win_idx),
        .fire_data (old_bit),
        .rsp_valid (rsp_valid),
        .rsp_id    (rsp_id),
        .rsp_data  (rsp_data)
    );
endmodule

// File: rtl/swap_lock_bus_chk.sv
module swap_lock_bus_chk #(
    parameter int N    = 4,
    parameter int ID_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    req_valid,
    input logic [N-1:0]    gnt,
    input logic            rsp_valid,
    input logic [ID_W-1:0] rsp_id
);
    logic [ID_W-1:0] seen_idx;

    always_comb begin
        seen_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) seen_idx = ID_W'(i);
        end
    end

    a_r1_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    a_r1_grant_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req_valid) == '0);

    a_r2_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_valid) |-> (|gnt));

    a_r4_done_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> rsp_valid);

    a_r4_done_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(|gnt));

    a_r4_done_id: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_id == $past(seen_idx)));
endmodule

bind swap_lock_bus swap_lock_bus_chk #(.N(NUM_REQ), .ID_W(ID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .gnt       (gnt),
    .rsp_valid (rsp_valid),
    .rsp_id    (rsp_id)
);

// File: tb/swap_lock_bus_test.sv
module swap_lock_bus_test;
    localparam int N  = 4;
    localparam int L  = 8;
    localparam int AW = 3;
    localparam int IW = 2;

    // vector: [8:7] id, [6:5] op, [4:2] addr, [1] wdata, [0] expected old bit
    localparam int NV = 12;
    localparam logic [8:0] VEC [0:NV-1] = '{
        {2'd0, 2'd0, 3'd3, 1'b0, 1'b0},  // R10 R8 fresh lock reads 0
        {2'd1, 2'd2, 3'd3, 1'b0, 1'b0},  // R5 swap free lock
        {2'd2, 2'd2, 3'd3, 1'b0, 1'b1},  // R9 swap held lock
        {2'd3, 2'd0, 3'd3, 1'b0, 1'b1},  // R5 R9 lock stayed set
        {2'd0, 2'd0, 3'd4, 1'b0, 1'b0},  // R12 neighbour untouched
        {2'd2, 2'd1, 3'd3, 1'b0, 1'b1},  // R7 release returns old 1
        {2'd1, 2'd0, 3'd3, 1'b0, 1'b0},  // R7 released
        {2'd3, 2'd3, 3'd3, 1'b0, 1'b0},  // R11 code 3 reads
        {2'd0, 2'd1, 3'd5, 1'b1, 1'b0},  // R7 write 1
        {2'd1, 2'd0, 3'd5, 1'b0, 1'b1},  // R8 read back
        {2'd2, 2'd3, 3'd5, 1'b0, 1'b1},  // R11 code 3 reads set word
        {2'd3, 2'd0, 3'd3, 1'b0, 1'b0}   // R11 R12 word 3 unchanged
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [2*N-1:0]  req_op = '0;
    logic [AW*N-1:0] req_addr = '0;
    logic [N-1:0]    req_wdata = '0;
    logic [N-1:0]    gnt;
    logic            rsp_valid;
    logic [IW-1:0]   rsp_id;
    logic            rsp_data;

    int total = 0;
    int bad   = 0;
    int model_last = N - 1;
    int zeros;

    always #5 clk = ~clk;

    swap_lock_bus #(.NUM_REQ(N), .NUM_LOCKS(L)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .gnt       (gnt),
        .rsp_valid (rsp_valid),
        .rsp_id    (rsp_id),
        .rsp_data  (rsp_data)
    );

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic set_fields(int id, int op, int addr, int wd);
        req_op[id*2 +: 2]     = 2'(op);
        req_addr[id*AW +: AW] = AW'(addr);
        req_wdata[id]         = 1'(wd);
    endtask

    task automatic do_one(int id, int op, int addr, int wd, int exp, string tag);
        @(negedge clk);
        set_fields(id, op, addr, wd);
        req_valid = N'(1) << id;
        #1;
        check(tag, "grant", int'(gnt), 1 << id);
        @(negedge clk);
        req_valid = '0;
        model_last = id;
        check("R4", "done pulse", int'(rsp_valid), 1);
        check("R4", "done id", int'(rsp_id), id);
        check(tag, "old value", int'(rsp_data), exp);
    endtask

    // Several requesters at once; order predicted from the round-robin rule.
    task automatic contend(logic [N-1:0] mask, int op, int addr, output int nzero);
        logic [N-1:0] pending;
        nzero = 0;
        @(negedge clk);
        pending = mask;
        for (int i = 0; i < N; i++) if (mask[i]) set_fields(i, op, addr, 0);
        req_valid = pending;
        while (pending != '0) begin
            int exp_id;
            exp_id = -1;
            for (int k = 1; k <= N; k++) begin
                int c;
                c = (model_last + k) % N;
                if (exp_id < 0 && pending[c]) exp_id = c;
            end
            #1;
            check("R3", "rr grant", int'(gnt), 1 << exp_id);
            @(negedge clk);
            pending[exp_id] = 1'b0;
            req_valid = pending;
            model_last = exp_id;
            check("R4", "done pulse", int'(rsp_valid), 1);
            check("R4", "done id", int'(rsp_id), exp_id);
            if (rsp_data == 1'b0) nzero++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10", "no pulse in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            do_one(int'(VEC[v][8:7]), int'(VEC[v][6:5]), int'(VEC[v][4:2]),
                   int'(VEC[v][1]), int'(VEC[v][0]), $sformatf("R5-table%0d", v));
        end

        // R6: all four test-and-set lock 7 in one cycle
        contend(4'b1111, 2, 7, zeros);
        check("R6", "single winner", zeros, 1);
        @(negedge clk);
        check("R4", "no pulse when idle", int'(rsp_valid), 0);

        do_one(2, 1, 7, 0, 1, "R7");   // release
        do_one(1, 2, 7, 0, 0, "R5");   // retake after release
        do_one(0, 0, 7, 0, 1, "R9");   // stays held

        contend(4'b1001, 0, 0, zeros); // R3: last holder 0 goes after 3
        check("R8", "reads of word 0", zeros, 2);

        // R10: reset mid-run clears locks and priority
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10", "pulse held low", int'(rsp_valid), 0);
        rst_n = 1'b1;
        model_last = N - 1;
        contend(4'b0101, 0, 7, zeros);
        check("R10", "lock 7 cleared", zeros, 2);
        do_one(3, 2, 1, 0, 0, "R12");
        do_one(2, 0, 2, 0, 0, "R12");

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule